// File: doc/BRIEF.md
# I2C Packet Header Sequencer

This block sits between a transmit word FIFO, a receive word FIFO and a byte-level I2C bit engine. Each transfer arrives in-band as three 32-bit header words. The first word marks the protocol. The second word gives the payload length. The third word carries the target address and the transfer options. After decoding the header, the sequencer issues a series of byte commands to the bit engine: start, address, write byte, read byte and end. Payload words are split into bytes for writes. Received bytes are packed into words for reads.

The third header word also chooses how the transfer finishes. It can end with a stop, end with a repeated start, or end with neither so that the next packet continues on the same bus ownership. The sequencer remembers that choice. A packet that follows a repeated start leaves out its own first start command. A packet that follows a continue leaves out both start and address. The sequencer reports a missing acknowledge, a lost arbitration and packet completion as single-cycle pulses.

Top module: `i2c_pkt_seq`

## Requirements
- R1: While idle, the sequencer pops nothing until the transmit FIFO level is at least 3. It then pops one word. If bit 4 of that word is 0, the word is dropped, no command is issued and the sequencer stays idle.
- R2: The low CNT_W bits of header word 1 give the byte count minus one. For a 7-bit target (word 2 bit 18 clear), the commands are START (op 0, data 0x00), then ADDR (op 1) with data {word2[7:1], word2[19]}. Word 2 bit 19 set means read.
- R3: With word 2 bit 18 set, the address is word2[9:0]. The address bytes are {5'b11110, a[9:8], 1'b0} and then a[7:0]. For a read, these are followed by START and then {5'b11110, a[9:8], 1'b1}.
- R4: With word 2 bit 20 set, the packet opens with START, then WRITE (op 2) of 0x01 whose acknowledge is ignored, then a second START before the address.
- R5: Write payload bytes are issued as WRITE commands, lowest byte of each 32-bit word first. A new word is popped only when the previous word is used up. A final partial word is used only up to the byte count.
- R6: Each READ command (op 3) carries data 0x01 on the last byte of a packet that does not end in continue, and 0x00 otherwise. Received bytes are packed lowest byte first. A word is pushed when it is full or after the last byte, with unused upper bytes zero.
- R7: The end action is chosen from word 2. With bit 15 set, no END is issued and the next packet starts with its payload. Bit 15 wins over bit 16. With bit 16 set, END (op 4) is issued with data 0x01, and the next packet leaves out its first START. Otherwise END is issued with data 0x00.
- R8: pkt_done_o pulses once after the END command completes, or after the last byte completes for a continue ending. It pulses only if word 2 bit 17 is set, or always when HAS_PKT_IRQ_EN is 0.
- R9: A missing acknowledge on an address byte or a write byte pulses nack_o. The sequencer then issues END with data 0x00 (stop), gives no pkt_done_o and returns to idle. Payload words that were not yet needed stay in the FIFO.
- R10: With word 2 bit 21 set, a missing acknowledge still pulses nack_o, but the packet carries on to its normal end and completion.
- R11: Arbitration loss pulses arb_lost_o. The sequencer issues no further command, returns to idle and forgets any pending repeated-start or continue chaining.
- R12: A presented command keeps its op and data stable until cmd_ready_i accepts it. cmd_hs_o follows word 2 bit 22 while a packet is active and is 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_data_i | input | 32 | Head word of the transmit FIFO |
| tx_level_i | input | LVL_W | Word count in the transmit FIFO |
| tx_pop_o | output | 1 | Pop the transmit FIFO head |
| rx_data_o | output | 32 | Packed receive word |
| rx_push_o | output | 1 | Push rx_data_o into the receive FIFO |
| cmd_valid_o | output | 1 | Command presented to the bit engine |
| cmd_op_o | output | 3 | Command code: 0 start, 1 address, 2 write, 3 read, 4 end |
| cmd_data_o | output | 8 | Byte to send, read NAK flag, or end kind |
| cmd_hs_o | output | 1 | High-speed mode for the active packet |
| cmd_ready_i | input | 1 | Bit engine accepts the command |
| eng_done_i | input | 1 | Bit engine finished the accepted command |
| eng_nack_i | input | 1 | No acknowledge seen, valid with eng_done_i |
| eng_rdata_i | input | 8 | Received byte, valid with eng_done_i |
| eng_arb_lost_i | input | 1 | Bit engine lost arbitration |
| nack_o | output | 1 | Missing-acknowledge pulse |
| arb_lost_o | output | 1 | Arbitration-loss pulse |
| pkt_done_o | output | 1 | Packet-complete pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit word split into four byte lanes, a 12-bit byte count and the per-packet completion enable present. With four lanes, a five- or six-byte packet crosses a word boundary and ends on a partial word, so both the pop-on-exhaustion path and the zero-padded final receive push are exercised. Because the per-packet enable is present, a read packet with bit 17 clear can show that completion is suppressed. The engine model stalls its ready signal every other cycle and can inject a missing acknowledge or a lost arbitration at any chosen command index.

// File: rtl/i2c_pkt_seq_pkg.sv
package i2c_pkt_seq_pkg;

  typedef enum logic [2:0] {
    CMD_START = 3'd0,
    CMD_ADDR  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_READ  = 3'd3,
    CMD_END   = 3'd4
  } cmd_op_e;

  typedef enum logic [1:0] {
    END_STOP   = 2'd0,
    END_RSTART = 2'd1,
    END_CONT   = 2'd2
  } end_kind_e;

  typedef struct packed {
    logic      hs;
    logic      nak_go;
    logic      start_byte;
    logic      rd;
    logic      ten;
    logic      ien;
    end_kind_e end_kind;
    logic [7:0] a7_byte;
    logic [7:0] ten_hi;
    logic [7:0] ten_lo;
  } hdr_cfg_t;

  localparam int unsigned PROTO_BIT = 4;

endpackage

// File: rtl/i2c_hdr_decode.sv
module i2c_hdr_decode
  import i2c_pkt_seq_pkg::*;
(
  input  logic [31:0] word_i,
  output hdr_cfg_t    cfg_o
);

  logic unused_bits;
  assign unused_bits = ^{word_i[31:23], word_i[14:10]};

  always_comb begin
    cfg_o.hs         = word_i[22];
    cfg_o.nak_go     = word_i[21];
    cfg_o.start_byte = word_i[20];
    cfg_o.rd         = word_i[19];
    cfg_o.ten        = word_i[18];
    cfg_o.ien        = word_i[17];
    if (word_i[15])      cfg_o.end_kind = END_CONT;
    else if (word_i[16]) cfg_o.end_kind = END_RSTART;
    else                 cfg_o.end_kind = END_STOP;
    cfg_o.a7_byte = {word_i[7:1], word_i[19]};
    cfg_o.ten_hi  = {5'b11110, word_i[9:8], 1'b0};
    cfg_o.ten_lo  = word_i[7:0];
  end

endmodule

// File: rtl/i2c_byte_lane.sv
module i2c_byte_lane #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned LANES  = WORD_W / 8,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              step_i,
  input  logic              last_i,
  input  logic              rd_i,
  input  logic [7:0]        rbyte_i,
  output logic              wrap_o,
  output logic [7:0]        wbyte_o,
  output logic [WORD_W-1:0] rx_word_o
);

  logic [LANE_W-1:0] lane_q;
  logic [WORD_W-1:0] wbuf_q, rbuf_q;

  assign wrap_o    = last_i || (lane_q == LANE_W'(LANES - 1));
  assign wbyte_o   = wbuf_q[8*lane_q +: 8];
  assign rx_word_o = rbuf_q | ({{(WORD_W-8){1'b0}}, rbyte_i} << (8*lane_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q <= '0;
      rbuf_q <= '0;
      wbuf_q <= '0;
    end else begin
      if (load_i) wbuf_q <= word_i;
      if (clear_i) begin
        lane_q <= '0;
        rbuf_q <= '0;
      end else if (step_i) begin
        if (wrap_o) begin
          lane_q <= '0;
          rbuf_q <= '0;
        end else begin
          lane_q <= lane_q + LANE_W'(1);
          if (rd_i) rbuf_q[8*lane_q +: 8] <= rbyte_i;
        end
      end
    end
  end

  // R5
  lane_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && wrap_o && !clear_i |=> lane_q == '0);

endmodule

// File: rtl/i2c_pkt_seq.sv
module i2c_pkt_seq
  import i2c_pkt_seq_pkg::*;
#(
  parameter int unsigned LVL_W          = 5,
  parameter int unsigned CNT_W          = 12,
  parameter bit          HAS_PKT_IRQ_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      tx_data_i,
  input  logic [LVL_W-1:0] tx_level_i,
  output logic             tx_pop_o,
  output logic [31:0]      rx_data_o,
  output logic             rx_push_o,
  output logic             cmd_valid_o,
  output logic [2:0]       cmd_op_o,
  output logic [7:0]       cmd_data_o,
  output logic             cmd_hs_o,
  input  logic             cmd_ready_i,
  input  logic             eng_done_i,
  input  logic             eng_nack_i,
  input  logic [7:0]       eng_rdata_i,
  input  logic             eng_arb_lost_i,
  output logic             nack_o,
  output logic             arb_lost_o,
  output logic             pkt_done_o
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_H1, ST_H2, ST_SB_START, ST_SB_BYTE, ST_START,
    ST_A1, ST_A2, ST_RS, ST_A3, ST_DATA, ST_END
  } state_e;

  state_e     state_q, entry_st;
  hdr_cfg_t   cfg_q, cfg_d;
  logic [CNT_W-1:0] rem_q;
  logic       wait_q, wvalid_q, abort_q, rs_q, cont_q;
  logic       nack_q, done_q, arb_q;
  logic       issuing, fin, arb, nack_hit, last, pkt_en, step, wrap;
  logic [7:0] wbyte;
  cmd_op_e    op;

  i2c_hdr_decode u_dec (.word_i(tx_data_i), .cfg_o(cfg_d));

  assign last   = (rem_q == '0);
  assign pkt_en = cfg_q.ien || !HAS_PKT_IRQ_EN;
  assign fin    = wait_q && eng_done_i;
  assign arb    = eng_arb_lost_i && (state_q != ST_IDLE);
  assign step   = fin && !arb && (state_q == ST_DATA);
  assign nack_hit = fin && !arb && eng_nack_i &&
                    ((state_q inside {ST_A1, ST_A2, ST_A3}) ||
                     (state_q == ST_DATA && !cfg_q.rd));

  always_comb begin
    tx_pop_o = 1'b0;
    unique case (state_q)
      ST_IDLE: tx_pop_o = (tx_level_i >= LVL_W'(3));
      ST_H1, ST_H2: tx_pop_o = 1'b1;
      ST_DATA: tx_pop_o = !cfg_q.rd && !wvalid_q && !wait_q && (tx_level_i != '0);
      default: tx_pop_o = 1'b0;
    endcase
  end

  i2c_byte_lane #(.WORD_W(32)) u_lane (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (state_q == ST_H2),
    .load_i   (tx_pop_o && state_q == ST_DATA),
    .word_i   (tx_data_i),
    .step_i   (step),
    .last_i   (last),
    .rd_i     (cfg_q.rd),
    .rbyte_i  (eng_rdata_i),
    .wrap_o   (wrap),
    .wbyte_o  (wbyte),
    .rx_word_o(rx_data_o)
  );

  assign rx_push_o = step && cfg_q.rd && wrap;

  // first command state of a new packet, skipping what chaining already did
  always_comb begin
    if (cont_q)                entry_st = ST_DATA;
    else if (cfg_d.start_byte) entry_st = rs_q ? ST_SB_BYTE : ST_SB_START;
    else                       entry_st = rs_q ? ST_A1 : ST_START;
  end

  always_comb begin
    issuing    = 1'b1;
    op         = CMD_START;
    cmd_data_o = 8'h00;
    unique case (state_q)
      ST_SB_START, ST_START, ST_RS: op = CMD_START;
      ST_SB_BYTE: begin op = CMD_WRITE; cmd_data_o = 8'h01; end
      ST_A1: begin op = CMD_ADDR; cmd_data_o = cfg_q.ten ? cfg_q.ten_hi : cfg_q.a7_byte; end
      ST_A2: begin op = CMD_ADDR; cmd_data_o = cfg_q.ten_lo; end
      ST_A3: begin op = CMD_ADDR; cmd_data_o = cfg_q.ten_hi | 8'h01; end
      ST_DATA: begin
        if (cfg_q.rd) begin
          op = CMD_READ;
          cmd_data_o = {7'd0, last && cfg_q.end_kind != END_CONT};
        end else begin
          op = CMD_WRITE;
          cmd_data_o = wbyte;
          issuing = wvalid_q;
        end
      end
      ST_END: begin
        op = CMD_END;
        cmd_data_o = {7'd0, !abort_q && cfg_q.end_kind == END_RSTART};
      end
      default: issuing = 1'b0;
    endcase
  end

  assign cmd_op_o    = op;
  assign cmd_valid_o = issuing && !wait_q;
  assign cmd_hs_o    = cfg_q.hs && (state_q != ST_IDLE);
  assign nack_o      = nack_q;
  assign arb_lost_o  = arb_q;
  assign pkt_done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cfg_q    <= '0;
      rem_q    <= '0;
      wait_q   <= 1'b0;
      wvalid_q <= 1'b0;
      abort_q  <= 1'b0;
      rs_q     <= 1'b0;
      cont_q   <= 1'b0;
      nack_q   <= 1'b0;
      done_q   <= 1'b0;
      arb_q    <= 1'b0;
    end else begin
      nack_q <= nack_hit;
      done_q <= 1'b0;
      arb_q  <= arb;
      if (arb) begin
        state_q  <= ST_IDLE;
        wait_q   <= 1'b0;
        wvalid_q <= 1'b0;
        rs_q     <= 1'b0;
        cont_q   <= 1'b0;
      end else begin
        if (cmd_valid_o && cmd_ready_i) wait_q <= 1'b1;
        if (fin) wait_q <= 1'b0;
        if (tx_pop_o && state_q == ST_DATA) wvalid_q <= 1'b1;
        if (step && wrap) wvalid_q <= 1'b0;
        unique case (state_q)
          ST_IDLE: if (tx_pop_o && tx_data_i[PROTO_BIT]) state_q <= ST_H1;
          ST_H1: begin
            rem_q   <= tx_data_i[CNT_W-1:0];
            state_q <= ST_H2;
          end
          ST_H2: begin
            cfg_q   <= cfg_d;
            abort_q <= 1'b0;
            rs_q    <= 1'b0;
            cont_q  <= 1'b0;
            state_q <= entry_st;
          end
          ST_SB_START: if (fin) state_q <= ST_SB_BYTE;
          ST_SB_BYTE:  if (fin) state_q <= ST_START;
          ST_START:    if (fin) state_q <= ST_A1;
          ST_RS:       if (fin) state_q <= ST_A3;
          ST_A1, ST_A2, ST_A3: if (fin) begin
            if (nack_hit && !cfg_q.nak_go) begin
              abort_q <= 1'b1;
              state_q <= ST_END;
            end else if (state_q == ST_A1 && cfg_q.ten) state_q <= ST_A2;
            else if (state_q == ST_A2 && cfg_q.rd)     state_q <= ST_RS;
            else                                        state_q <= ST_DATA;
          end
          ST_DATA: if (fin) begin
            if (nack_hit && !cfg_q.nak_go) begin
              abort_q  <= 1'b1;
              wvalid_q <= 1'b0;
              state_q  <= ST_END;
            end else if (last) begin
              if (cfg_q.end_kind == END_CONT) begin
                done_q  <= pkt_en;
                cont_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_END;
              end
            end else begin
              rem_q <= rem_q - CNT_W'(1);
            end
          end
          ST_END: if (fin) begin
            done_q  <= !abort_q && pkt_en;
            rs_q    <= !abort_q && cfg_q.end_kind == END_RSTART;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R12
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i && !eng_arb_lost_i |=>
      cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_data_o));

  // R11
  arb_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_arb_lost_i && state_q != ST_IDLE |=> state_q == ST_IDLE && !cmd_valid_o);

  // R1
  pop_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> tx_level_i != '0);

  // R9
  nack_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_o |-> $past(eng_done_i && eng_nack_i));

  // R8
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |-> $past(eng_done_i) && !arb_lost_o);

endmodule

// File: tb/i2c_pkt_seq_tb_top.sv
module i2c_pkt_seq_tb_top;
  import i2c_pkt_seq_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] tx_data_i = '0;
  logic [4:0]  tx_level_i = '0;
  logic        tx_pop_o, rx_push_o, cmd_valid_o, cmd_hs_o, cmd_ready_i;
  logic [31:0] rx_data_o;
  logic [2:0]  cmd_op_o;
  logic [7:0]  cmd_data_o;
  logic        eng_done_i = 1'b0, eng_nack_i = 1'b0, eng_arb_lost_i = 1'b0;
  logic [7:0]  eng_rdata_i = '0;
  logic        nack_o, arb_lost_o, pkt_done_o;

  always #4 clk_i = ~clk_i;

  i2c_pkt_seq dut_i (
    .clk_i, .rst_ni, .tx_data_i, .tx_level_i, .tx_pop_o, .rx_data_o, .rx_push_o,
    .cmd_valid_o, .cmd_op_o, .cmd_data_o, .cmd_hs_o, .cmd_ready_i,
    .eng_done_i, .eng_nack_i, .eng_rdata_i, .eng_arb_lost_i,
    .nack_o, .arb_lost_o, .pkt_done_o
  );

  typedef struct packed { logic [2:0] op; logic [7:0] data; } exp_t;

  logic [31:0] fifo[$];
  exp_t        exp_q[$];
  logic [31:0] exp_rx[$];
  int checks = 0, errors = 0;
  int test_id = 0, seen_id = 0, nack_sel = -1, arb_sel = -1;
  int cmd_idx = 0, cur_idx = 0, rd_ctr = 0;
  int n_nack = 0, n_done = 0, n_arb = 0, n_cmd = 0;
  logic exp_hs = 1'b0;
  logic busy = 1'b0, ready_q = 1'b0;
  logic [7:0] cur_rd = '0;
  int lat = 0;

  assign cmd_ready_i = ready_q && !busy;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // FIFO model: pop on edge, present head at negedge
  always @(posedge clk_i) if (rst_ni && tx_pop_o && fifo.size() > 0) void'(fifo.pop_front());
  always @(negedge clk_i) begin
    tx_level_i = 5'(fifo.size());
    tx_data_i  = (fifo.size() > 0) ? fifo[0] : 32'h0;
  end

  // engine model and scoreboard monitor
  always @(posedge clk_i) begin
    if (rst_ni) begin
      if (test_id != seen_id) begin
        seen_id = test_id; cmd_idx = 0; rd_ctr = 0;
        n_nack = 0; n_done = 0; n_arb = 0; n_cmd = 0;
      end
      if (nack_o) n_nack++;
      if (pkt_done_o) n_done++;
      if (arb_lost_o) n_arb++;
      if (rx_push_o) begin
        if (exp_rx.size() == 0) check(1'b0, "R6 unexpected rx push", rx_data_o, 0);
        else begin
          logic [31:0] e;
          e = exp_rx.pop_front();
          check(rx_data_o == e, "R6 rx word", rx_data_o, e);
        end
      end
      eng_done_i <= 1'b0; eng_nack_i <= 1'b0; eng_arb_lost_i <= 1'b0;
      ready_q <= ~ready_q;
      if (busy) begin
        if (lat == 0) begin
          busy <= 1'b0;
          eng_done_i <= 1'b1;
          eng_nack_i <= (cur_idx == nack_sel);
          eng_arb_lost_i <= (cur_idx == arb_sel);
          eng_rdata_i <= cur_rd;
        end else lat <= lat - 1;
      end else if (cmd_valid_o && cmd_ready_i) begin
        n_cmd++;
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected command", {cmd_op_o, cmd_data_o}, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check({cmd_op_o, cmd_data_o} == {e.op, e.data}, "R2 command op/data",
                {cmd_op_o, cmd_data_o}, {e.op, e.data});
          check(cmd_hs_o == exp_hs, "R12 hs level", cmd_hs_o, exp_hs);
        end
        cur_idx = cmd_idx; cmd_idx++;
        if (cmd_op_o == 3'd3) begin cur_rd = 8'h30 + 8'(rd_ctr); rd_ctr++; end
        busy <= 1'b1; lat <= 1;
      end
    end
  end

  task automatic start_test(input int id);
    @(negedge clk_i);
    test_id = id; nack_sel = -1; arb_sel = -1;
    @(negedge clk_i);
  endtask

  task automatic ex(input logic [2:0] op, input logic [7:0] d);
    exp_q.push_back('{op: op, data: d});
  endtask

  task automatic hdr(input logic [31:0] w2, input int n);
    fifo.push_back(32'h0001_0010);
    fifo.push_back(32'(n - 1));
    fifo.push_back(w2);
  endtask

  task automatic settle();
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk_i);
    repeat (30) @(negedge clk_i);
  endtask

  task automatic counts(input string req, input int nk, input int dn, input int ar);
    check(exp_q.size() == 0, {req, " commands left"}, exp_q.size(), 0);
    check(exp_rx.size() == 0, {req, " rx left"}, exp_rx.size(), 0);
    check(n_nack == nk, {req, " nack pulses"}, n_nack, nk);
    check(n_done == dn, {req, " done pulses"}, n_done, dn);
    check(n_arb == ar, {req, " arb pulses"}, n_arb, ar);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check({cmd_valid_o, tx_pop_o, rx_push_o, nack_o, pkt_done_o, arb_lost_o, cmd_hs_o} == '0,
          "R12 reset outputs", {cmd_valid_o, tx_pop_o, pkt_done_o}, 0);

    // R1: non-protocol word dropped, idle until three words
    start_test(1);
    fifo.push_back(32'h0001_0000);
    repeat (20) @(negedge clk_i);
    check(fifo.size() == 1, "R1 no pop below three", fifo.size(), 1);
    fifo.push_back(32'h0); fifo.push_back(32'h0);
    repeat (20) @(negedge clk_i);
    check(fifo.size() == 2, "R1 one word dropped", fifo.size(), 2);
    check(n_cmd == 0, "R1 no command", n_cmd, 0);
    fifo.delete();

    // R2 R5 R8: 7-bit write, 6 bytes, stop
    start_test(2);
    hdr(32'h0002_00A0, 6); fifo.push_back(32'h4433_2211); fifo.push_back(32'h0000_6655);
    ex(0, 8'h00); ex(1, 8'hA0);
    ex(2, 8'h11); ex(2, 8'h22); ex(2, 8'h33); ex(2, 8'h44); ex(2, 8'h55); ex(2, 8'h66);
    ex(4, 8'h00);
    settle(); counts("R5", 0, 1, 0);

    // R6 R8: 7-bit read, 5 bytes, completion disabled
    start_test(3);
    hdr(32'h0008_003A, 5);
    ex(0, 8'h00); ex(1, 8'h3B); ex(3, 0); ex(3, 0); ex(3, 0); ex(3, 0); ex(3, 8'h01); ex(4, 8'h00);
    exp_rx.push_back(32'h3332_3130); exp_rx.push_back(32'h0000_0034);
    settle(); counts("R6", 0, 0, 0);

    // R7: repeated-start end, next packet skips START
    start_test(4);
    hdr(32'h0003_00A0, 1); fifo.push_back(32'h0000_005A);
    ex(0, 0); ex(1, 8'hA0); ex(2, 8'h5A); ex(4, 8'h01);
    settle(); counts("R7 rstart", 0, 1, 0);
    start_test(5);
    hdr(32'h000A_00A0, 2);
    ex(1, 8'hA1); ex(3, 0); ex(3, 8'h01); ex(4, 8'h00);
    exp_rx.push_back(32'h0000_3130);
    settle(); counts("R7 after rstart", 0, 1, 0);

    // R7 R8: continue end wins over repeated start
    start_test(6);
    hdr(32'h0003_80A0, 2); fifo.push_back(32'h0000_8877);
    ex(0, 0); ex(1, 8'hA0); ex(2, 8'h77); ex(2, 8'h88);
    settle(); counts("R7 continue", 0, 1, 0);
    start_test(7);
    hdr(32'h0002_00A0, 1); fifo.push_back(32'h0000_0099);
    ex(2, 8'h99); ex(4, 8'h00);
    settle(); counts("R7 after continue", 0, 1, 0);

    // R3: 10-bit write and read
    start_test(8);
    hdr(32'h0006_02A5, 1); fifo.push_back(32'h0000_00C4);
    ex(0, 0); ex(1, 8'hF4); ex(1, 8'hA5); ex(2, 8'hC4); ex(4, 8'h00);
    settle(); counts("R3 write", 0, 1, 0);
    start_test(9);
    hdr(32'h000E_01C3, 1);
    ex(0, 0); ex(1, 8'hF2); ex(1, 8'hC3); ex(0, 0); ex(1, 8'hF3); ex(3, 8'h01); ex(4, 8'h00);
    exp_rx.push_back(32'h0000_0030);
    settle(); counts("R3 read", 0, 1, 0);

    // R4 R12: start byte with ignored NAK, high-speed
    start_test(10);
    nack_sel = 1; exp_hs = 1'b1;
    hdr(32'h0052_00A0, 1); fifo.push_back(32'h0000_0012);
    ex(0, 0); ex(2, 8'h01); ex(0, 0); ex(1, 8'hA0); ex(2, 8'h12); ex(4, 8'h00);
    settle(); counts("R4", 0, 1, 0);
    exp_hs = 1'b0;

    // R9: NAK on address
    start_test(11);
    nack_sel = 1;
    hdr(32'h0002_00A0, 2); fifo.push_back(32'h0000_2211);
    ex(0, 0); ex(1, 8'hA0); ex(4, 8'h00);
    settle(); counts("R9 addr", 1, 0, 0);
    check(fifo.size() == 1, "R9 payload left", fifo.size(), 1);
    fifo.delete();

    // R10: continue on NAK
    start_test(12);
    nack_sel = 2;
    hdr(32'h0022_00A0, 2); fifo.push_back(32'h0000_2211);
    ex(0, 0); ex(1, 8'hA0); ex(2, 8'h11); ex(2, 8'h22); ex(4, 8'h00);
    settle(); counts("R10", 1, 1, 0);

    // R11: arbitration loss forgets chaining
    start_test(13);
    hdr(32'h0003_00A0, 1); fifo.push_back(32'h0000_005A);
    ex(0, 0); ex(1, 8'hA0); ex(2, 8'h5A); ex(4, 8'h01);
    settle(); counts("R11 setup", 0, 1, 0);
    start_test(14);
    arb_sel = 0;
    hdr(32'h0002_00A0, 1); fifo.push_back(32'h0000_00EE);
    ex(1, 8'hA0);
    settle(); counts("R11 arb", 0, 0, 1);
    check(fifo.size() == 1, "R11 payload left", fifo.size(), 1);
    fifo.delete();
    start_test(15);
    hdr(32'h0002_00A0, 1); fifo.push_back(32'h0000_003C);
    ex(0, 0); ex(1, 8'hA0); ex(2, 8'h3C); ex(4, 8'h00);
    settle(); counts("R11 after arb", 0, 1, 0);

    // R9: NAK on a middle write byte
    start_test(16);
    nack_sel = 3;
    hdr(32'h0002_00A0, 3); fifo.push_back(32'h0003_0201);
    ex(0, 0); ex(1, 8'hA0); ex(2, 8'h01); ex(2, 8'h02); ex(4, 8'h00);
    settle(); counts("R9 data", 1, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule